// File: doc/BRIEF.md
# Data-Bus Error Capture and NMI Request Generator

This block watches the error strobes that a data bus raises for failed stores and failed non-blocking loads. The first such error records the failing access's base address in a capture register. That register then locks, and the block issues a one-cycle non-maskable interrupt request together with a 32-bit cause code that names the error source. Until the lock is cleared, later bus errors are dropped: they move neither the address nor the request line. The lock is cleared by reset or by a strobe on a separate unlock write.

An asynchronous NMI pin is merged into the same request line. The pin passes through a flip-flop synchronizer and a rising-edge detector. Pin requests are honoured whether or not the capture register is locked. If a pin request and an accepted bus error fall in the same cycle, one request pulse is raised and it carries the bus-error cause.

Top module: `berr_nmi_gen`

## Requirements
- R1: After reset, `nmi_req` is 0, `nmi_cause` is 0x0000_0000, `err_addr` is 0 and the capture register is unlocked.
- R2: A bus error strobe sampled at a clock edge while unlocked loads its address into `err_addr` and locks at that edge. `nmi_req` is high for exactly the one cycle that follows.
- R3: The cause codes are 0xF000_0000 for a store error, 0xF000_0001 for a non-blocking load error and 0x0000_0000 for a pin request. They appear on `nmi_cause` in the same cycle as the `nmi_req` pulse.
- R4: While locked, store and load error strobes raise no request and leave `err_addr` unchanged.
- R5: When store and load errors are strobed in the same cycle while unlocked, the store wins: its address is captured and its cause is reported.
- R6: An `unlock_wr` strobe clears the lock at that edge. An error that arrives in the same cycle as the unlock is judged against the lock state before that edge: it is dropped if the register was locked, and it is captured (leaving the register locked) if it was unlocked.
- R7: The pin passes through two synchronizer flops and a rising-edge detector. A pin that goes high between two edges gives `nmi_req` after the third following edge. A pin held high gives only one request, and the pin must return low before it can trigger again.
- R8: Pin requests are honoured while the capture register is locked. They report cause 0x0000_0000 and leave `err_addr` unchanged.
- R9: A pin request and an accepted bus error in the same cycle give a single pulse with the bus-error cause, and the address is captured.
- R10: A pin pulse that rises and falls between two clock edges is not seen.
- R11: `nmi_cause` holds its last value between request pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_err | input | 1 | Store bus error strobe |
| st_addr | input | ADDR_W | Base address of the failing store |
| ld_err | input | 1 | Non-blocking load bus error strobe |
| ld_addr | input | ADDR_W | Base address of the failing load |
| unlock_wr | input | 1 | Write strobe that unlocks the capture register |
| nmi_pin | input | 1 | Asynchronous external NMI request |
| nmi_req | output | 1 | One-cycle NMI request pulse |
| nmi_cause | output | 32 | Cause code of the latest request |
| err_addr | output | ADDR_W | Captured first-error address |

## Verification
The bench builds the block at its default values: 32-bit addresses and a two-stage synchronizer. At those values the three-edge pin latency can be counted exactly, so a pin rise can be lined up with a bus error in the same cycle. Addresses whose upper and lower halves differ show any truncation of the capture path. Each directed task places the unlock strobe, the pin and the error strobes at known edges. This covers the locked, unlocked and coincident cases, including the unlock-with-error corners.

// File: rtl/berr_pkg.sv
package berr_pkg;

   localparam int CAUSE_W = 32;

   localparam logic [CAUSE_W-1:0] CAUSE_STORE = 32'hF000_0000;
   localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 32'hF000_0001;
   localparam logic [CAUSE_W-1:0] CAUSE_PIN   = 32'h0000_0000;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_STORE = 2'd1,
      SRC_LOAD  = 2'd2
   } bus_src_e;

   function automatic logic [CAUSE_W-1:0] bus_cause(input bus_src_e s);
      return (s == SRC_STORE) ? CAUSE_STORE : CAUSE_LOAD;
   endfunction

endpackage

// File: rtl/berr_pin_sync.sv
module berr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("berr_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_async};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;

   // R7
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/berr_capture.sv
module berr_capture
   import berr_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_err,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              ld_err,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              unlock_wr,
   output logic              accept,
   output bus_src_e          src,
   output logic              locked,
   output logic [ADDR_W-1:0] err_addr
);

   logic              lock_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] pick_addr;

   always_comb begin
      src       = SRC_NONE;
      pick_addr = addr_q;
      if (st_err) begin
         src       = SRC_STORE;
         pick_addr = st_addr;
      end else if (ld_err) begin
         src       = SRC_LOAD;
         pick_addr = ld_addr;
      end
   end

   assign accept = (src != SRC_NONE) && !lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         addr_q <= '0;
      end else begin
         if (accept) begin
            lock_q <= 1'b1;
            addr_q <= pick_addr;
         end else if (unlock_wr) begin
            lock_q <= 1'b0;
         end
      end
   end

   assign locked   = lock_q;
   assign err_addr = addr_q;

   // R4
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(addr_q));

   // R2
   first_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_err || ld_err) && !lock_q) |=> lock_q);

endmodule

// File: rtl/berr_nmi_gen.sv
module berr_nmi_gen
   import berr_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_err,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              ld_err,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              unlock_wr,
   input  logic              nmi_pin,
   output logic              nmi_req,
   output logic [31:0]       nmi_cause,
   output logic [ADDR_W-1:0] err_addr
);

   generate
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
         $error("berr_nmi_gen: ADDR_W out of range");
      end
   endgenerate

   logic         bus_take;
   bus_src_e     bus_src;
   logic         cap_locked;
   logic         pin_rise;
   logic         req_q;
   logic [31:0]  cause_q;

   berr_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_err    (st_err),
      .st_addr   (st_addr),
      .ld_err    (ld_err),
      .ld_addr   (ld_addr),
      .unlock_wr (unlock_wr),
      .accept    (bus_take),
      .src       (bus_src),
      .locked    (cap_locked),
      .err_addr  (err_addr)
   );

   berr_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (nmi_pin),
      .rise      (pin_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         cause_q <= CAUSE_PIN;
      end else begin
         req_q <= bus_take | pin_rise;
         if (bus_take)
            cause_q <= bus_cause(bus_src);
         else if (pin_rise)
            cause_q <= CAUSE_PIN;
      end
   end

   assign nmi_req   = req_q;
   assign nmi_cause = cause_q;

   // R5
   store_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_err && ld_err && !cap_locked) |=> (nmi_req && nmi_cause == CAUSE_STORE));

   // R8
   pin_honoured_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rise |=> nmi_req);

   // R11
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_take || pin_rise) |=> $stable(nmi_cause));

endmodule

// File: tb/sim_berr_nmi_gen.sv
module sim_berr_nmi_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_err = 1'b0;
   logic [31:0] st_addr = '0;
   logic        ld_err = 1'b0;
   logic [31:0] ld_addr = '0;
   logic        unlock_wr = 1'b0;
   logic        nmi_pin = 1'b0;
   logic        nmi_req;
   logic [31:0] nmi_cause;
   logic [31:0] err_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   berr_nmi_gen u0 (
      .clk(clk), .rst_n(rst_n), .st_err(st_err), .st_addr(st_addr),
      .ld_err(ld_err), .ld_addr(ld_addr), .unlock_wr(unlock_wr),
      .nmi_pin(nmi_pin), .nmi_req(nmi_req), .nmi_cause(nmi_cause),
      .err_addr(err_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_unlock();
      unlock_wr = 1'b1;
      tick();
      unlock_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 nmi_req", {31'b0, nmi_req}, 32'd0);
      chk("R1 cause", nmi_cause, 32'h0);
      chk("R1 err_addr", err_addr, 32'h0);
   endtask

   task automatic t_store_first();
      st_err = 1'b1; st_addr = 32'h2000_1040;
      tick();
      st_err = 1'b0;
      chk("R2 store pulse", {31'b0, nmi_req}, 32'd1);
      chk("R3 store cause", nmi_cause, 32'hF000_0000);
      chk("R2 store addr", err_addr, 32'h2000_1040);
      tick();
      chk("R2 pulse one cycle", {31'b0, nmi_req}, 32'd0);
      chk("R11 cause held", nmi_cause, 32'hF000_0000);
   endtask

   task automatic t_locked_ignore();
      ld_err = 1'b1; ld_addr = 32'h3000_0008;
      tick();
      ld_err = 1'b0;
      chk("R4 load dropped", {31'b0, nmi_req}, 32'd0);
      chk("R4 addr kept", err_addr, 32'h2000_1040);
      st_err = 1'b1; st_addr = 32'h4000_0100;
      tick();
      st_err = 1'b0;
      chk("R4 store dropped", {31'b0, nmi_req}, 32'd0);
      chk("R4 addr kept 2", err_addr, 32'h2000_1040);
   endtask

   task automatic t_unlock_load();
      do_unlock();
      chk("R6 unlock no pulse", {31'b0, nmi_req}, 32'd0);
      ld_err = 1'b1; ld_addr = 32'h5A5A_00C0;
      tick();
      ld_err = 1'b0;
      chk("R2 load pulse", {31'b0, nmi_req}, 32'd1);
      chk("R3 load cause", nmi_cause, 32'hF000_0001);
      chk("R2 load addr", err_addr, 32'h5A5A_00C0);
      tick();
   endtask

   task automatic t_simultaneous();
      do_unlock();
      st_err = 1'b1; st_addr = 32'h8000_0A00;
      ld_err = 1'b1; ld_addr = 32'h9000_0B00;
      tick();
      st_err = 1'b0; ld_err = 1'b0;
      chk("R5 pulse", {31'b0, nmi_req}, 32'd1);
      chk("R5 store cause", nmi_cause, 32'hF000_0000);
      chk("R5 store addr", err_addr, 32'h8000_0A00);
      tick();
   endtask

   task automatic t_unlock_with_err_locked();
      unlock_wr = 1'b1;
      ld_err = 1'b1; ld_addr = 32'h1111_2222;
      tick();
      unlock_wr = 1'b0; ld_err = 1'b0;
      chk("R6 locked err dropped", {31'b0, nmi_req}, 32'd0);
      chk("R6 addr kept", err_addr, 32'h8000_0A00);
      ld_err = 1'b1; ld_addr = 32'h3333_4444;
      tick();
      ld_err = 1'b0;
      chk("R6 now unlocked pulse", {31'b0, nmi_req}, 32'd1);
      chk("R6 now unlocked addr", err_addr, 32'h3333_4444);
      tick();
   endtask

   task automatic t_unlocked_err_with_unlock();
      do_unlock();
      unlock_wr = 1'b1;
      st_err = 1'b1; st_addr = 32'h6000_0040;
      tick();
      unlock_wr = 1'b0; st_err = 1'b0;
      chk("R6 capture wins pulse", {31'b0, nmi_req}, 32'd1);
      chk("R6 capture wins addr", err_addr, 32'h6000_0040);
      ld_err = 1'b1; ld_addr = 32'h7000_0080;
      tick();
      ld_err = 1'b0;
      chk("R6 still locked", {31'b0, nmi_req}, 32'd0);
      chk("R6 still locked addr", err_addr, 32'h6000_0040);
   endtask

   task automatic t_pin_locked();
      nmi_pin = 1'b1;
      tick();
      chk("R7 edge1 none", {31'b0, nmi_req}, 32'd0);
      tick();
      chk("R7 edge2 none", {31'b0, nmi_req}, 32'd0);
      tick();
      chk("R8 pin pulse", {31'b0, nmi_req}, 32'd1);
      chk("R3 pin cause", nmi_cause, 32'h0);
      chk("R8 addr kept", err_addr, 32'h6000_0040);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R7 held single", {31'b0, nmi_req}, 32'd0);
      end
      nmi_pin = 1'b0;
      tick(); tick(); tick();
      nmi_pin = 1'b1;
      tick(); tick(); tick();
      chk("R7 retrigger", {31'b0, nmi_req}, 32'd1);
      nmi_pin = 1'b0;
      tick(); tick(); tick();
   endtask

   task automatic t_short_pulse();
      @(posedge clk);
      #2 nmi_pin = 1'b1;
      #2 nmi_pin = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         chk("R10 short lost", {31'b0, nmi_req}, 32'd0);
         tick();
      end
   endtask

   task automatic t_pin_and_err();
      do_unlock();
      nmi_pin = 1'b1;
      tick();
      tick();
      st_err = 1'b1; st_addr = 32'hC0DE_0100;
      tick();
      st_err = 1'b0;
      chk("R9 pulse", {31'b0, nmi_req}, 32'd1);
      chk("R9 bus cause", nmi_cause, 32'hF000_0000);
      chk("R9 addr", err_addr, 32'hC0DE_0100);
      tick();
      chk("R9 single pulse", {31'b0, nmi_req}, 32'd0);
      nmi_pin = 1'b0;
      tick(); tick(); tick();
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog all-R actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_store_first();
      t_locked_ignore();
      t_unlock_load();
      t_simultaneous();
      t_unlock_with_err_locked();
      t_unlocked_err_with_unlock();
      t_pin_locked();
      t_short_pulse();
      t_pin_and_err();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule